// File: doc/BRIEF.md
# Programmable address window decoder

This block resolves a 44-bit physical address to a 4-bit destination identifier by searching a bank of windows that software programs. Each window has an enable, a destination identifier and an inclusive address range. Bounds are kept at 64 MB granularity, so only address bits 43:26 take part in the compare. Software reaches every window field, and one unit-level control bit, through a flat 32-bit register port with immediate readback. Firmware can therefore read the destination of a window it parked at the top of the bank before it switches that window off.

A lookup is offered with `lk_valid` and `lk_addr`, and its verdict appears registered one cycle later. A small result state machine holds the verdict. Its states are `RES_IDLE` (no lookup last cycle), `RES_HIT` (an enabled window matched), `RES_MISS` (nothing matched and bypass is clear) and `RES_PASS` (nothing matched and bypass is set). On every clock the next state is picked from the current lookup alone. `!lk_valid` goes to `RES_IDLE`. Valid with a match goes to `RES_HIT`. Valid with no match goes to `RES_MISS` when bypass is clear and to `RES_PASS` when it is set. When several enabled windows cover the address, the lowest-numbered one wins.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and the bypass bit is clear. Every register reads zero, and `res_valid`, `res_hit` and `res_miss` are low with `res_target` and `res_index` zero.
- R2: Window w has its control register at byte address w*0x10. Bit 0 is the enable and bits 11:8 are the destination. All other bits read zero and ignore writes.
- R3: Window w has its low bound at w*0x10+0x8 and its high bound at w*0x10+0xC. Register bits 27:10 hold address bits 43:26, and the other bits read zero. Offset 0x4 reads zero.
- R4: An enabled window matches when low <= addr[43:26] <= high, inclusive at both ends. Address bits 25:0 have no effect.
- R5: A window whose enable bit is clear never matches, whatever its bounds hold.
- R6: When several enabled windows match, `res_index` and `res_target` come from the lowest-numbered one.
- R7: With bypass clear, an unmatched lookup gives `res_miss` high for exactly one cycle, with `res_hit` low and `res_target` and `res_index` zero.
- R8: The unit control register sits at byte address 0x100, with the bypass bit at bit 1. With bypass set, an unmatched lookup gives `res_valid` high with `res_hit` low, `res_miss` low and `res_target` zero.
- R9: The result is registered. `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and all result outputs are zero otherwise.
- R10: A lookup presented in the same cycle as a register write uses the configuration from before that write. The next lookup uses the new one.
- R11: The unit control register reads back only bit 1, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at `reg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 44 | Lookup physical address |
| res_valid | output | 1 | Result present, one cycle after the request |
| res_hit | output | 1 | An enabled window matched |
| res_miss | output | 1 | No match and bypass clear |
| res_target | output | 4 | Destination of the winning window |
| res_index | output | 4 | Number of the winning window |

## Verification
A corrupted window field shows at the ports in two ways. It appears in `reg_rdata` in the same cycle its address is presented. It also appears in the verdict of any lookup that touches that window one cycle later, as a wrong index, a wrong destination or a spurious miss. A wrong result state shows on the very next clock as a `res_valid`/`res_hit`/`res_miss` triple that disagrees with the previous cycle's request, because the bench compares the full result on every clock. Probes sit exactly on the bounds, on overlapping windows and on disabled windows. Writes coincide with lookups, so that an off-by-one compare, a reversed priority or a bypass that leaks through is seen within one lookup.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
    localparam int PA_W        = 44;
    localparam int SLICE_LSB   = 26;
    localparam int SLICE_W     = PA_W - SLICE_LSB;
    localparam int BND_REG_LSB = 10;
    localparam int DEST_W      = 4;
    localparam int DEST_LSB    = 8;

    typedef struct packed {
        logic               en;
        logic [DEST_W-1:0]  dest;
        logic [SLICE_W-1:0] lo;
        logic [SLICE_W-1:0] hi;
    } win_cfg_t;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2,
        RES_PASS = 2'd3
    } res_state_t;
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
#(
    parameter int NWIN = 16,
    localparam int IDX_W = $clog2(NWIN),
    localparam int RA_W  = IDX_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output win_cfg_t        cfg_o [NWIN],
    output logic            bypass_o
);
    logic             win_area;
    logic             unit_sel;
    logic [IDX_W-1:0] win_sel;
    logic [1:0]       slot;
    win_cfg_t         cfg_q [NWIN];
    logic             bypass_q;
    logic             unused_bits;

    assign win_area = !reg_addr[RA_W-1];
    assign unit_sel = reg_addr[RA_W-1] && (reg_addr[RA_W-2:0] == '0);
    assign win_sel  = reg_addr[IDX_W+3:4];
    assign slot     = reg_addr[3:2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:28], reg_wdata[7:2]};

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (reg_wr && win_area && win_sel == IDX_W'(i)) begin
                unique case (slot)
                    2'd0: begin
                        cfg_q[i].en   <= reg_wdata[0];
                        cfg_q[i].dest <= reg_wdata[DEST_LSB +: DEST_W];
                    end
                    2'd2: cfg_q[i].lo <= reg_wdata[BND_REG_LSB +: SLICE_W];
                    2'd3: cfg_q[i].hi <= reg_wdata[BND_REG_LSB +: SLICE_W];
                    default: ;
                endcase
            end
        end
        assign cfg_o[i] = cfg_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bypass_q <= 1'b0;
        else if (reg_wr && unit_sel)
            bypass_q <= reg_wdata[1];
    end
    assign bypass_o = bypass_q;

    always_comb begin
        reg_rdata = '0;
        if (win_area) begin
            unique case (slot)
                2'd0: begin
                    reg_rdata[0]                   = cfg_q[win_sel].en;
                    reg_rdata[DEST_LSB +: DEST_W]  = cfg_q[win_sel].dest;
                end
                2'd2: reg_rdata[BND_REG_LSB +: SLICE_W] = cfg_q[win_sel].lo;
                2'd3: reg_rdata[BND_REG_LSB +: SLICE_W] = cfg_q[win_sel].hi;
                default: ;
            endcase
        end else if (unit_sel) begin
            reg_rdata[1] = bypass_q;
        end
    end

    // R11
    bypass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && unit_sel) |=> (bypass_o == $past(reg_wdata[1])));
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
#(
    parameter int NWIN = 16,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  win_cfg_t           cfg_i [NWIN],
    input  logic [SLICE_W-1:0] slice_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [DEST_W-1:0]  dest_o
);
    logic [NWIN-1:0] hit;

    for (genvar i = 0; i < NWIN; i++) begin : g_cmp
        assign hit[i] = cfg_i[i].en
                     && (slice_i >= cfg_i[i].lo)
                     && (slice_i <= cfg_i[i].hi);
    end

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    assign dest_o = cfg_i[idx_o].dest;
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import addrwin_pkg::*;
#(
    parameter int NWIN = 16,
    localparam int IDX_W = $clog2(NWIN),
    localparam int RA_W  = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [PA_W-1:0]   lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [DEST_W-1:0] res_target,
    output logic [IDX_W-1:0]  res_index
);
    win_cfg_t          cfg [NWIN];
    logic              bypass;
    logic              m_any;
    logic [IDX_W-1:0]  m_idx;
    logic [DEST_W-1:0] m_dest;
    res_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DEST_W-1:0] dest_q;
    logic              unused_low;

    assign unused_low = ^lk_addr[SLICE_LSB-1:0];

    addrwin_regs #(.NWIN(NWIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg),
        .bypass_o  (bypass)
    );

    addrwin_match #(.NWIN(NWIN)) u_match (
        .cfg_i   (cfg),
        .slice_i (lk_addr[PA_W-1:SLICE_LSB]),
        .any_o   (m_any),
        .idx_o   (m_idx),
        .dest_o  (m_dest)
    );

    always_comb begin
        if (!lk_valid)   state_d = RES_IDLE;
        else if (m_any)  state_d = RES_HIT;
        else if (bypass) state_d = RES_PASS;
        else             state_d = RES_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RES_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            dest_q <= '0;
        end else begin
            idx_q  <= (state_d == RES_HIT) ? m_idx  : '0;
            dest_q <= (state_d == RES_HIT) ? m_dest : '0;
        end
    end

    always_comb begin
        res_valid  = 1'b0;
        res_hit    = 1'b0;
        res_miss   = 1'b0;
        res_target = '0;
        res_index  = '0;
        unique case (state_q)
            RES_IDLE: ;
            RES_HIT: begin
                res_valid  = 1'b1;
                res_hit    = 1'b1;
                res_target = dest_q;
                res_index  = idx_q;
            end
            RES_MISS: begin
                res_valid = 1'b1;
                res_miss  = 1'b1;
            end
            RES_PASS: res_valid = 1'b1;
            default: ;
        endcase
    end

    // R7
    miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !m_any && !bypass) |=> (res_miss && !res_hit && res_target == '0));

    // R8
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !m_any && bypass) |=> (res_valid && !res_miss && !res_hit));

    // R9
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R9
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && !res_miss));

    // R6
    winner_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && m_any) |=> (res_hit && res_index == $past(m_idx)));
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [43:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [3:0]  res_target, res_index;

    always #2.5 clk = ~clk;

    addr_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_target(res_target), .res_index(res_index)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit        m_en  [NW];
    bit [3:0]  m_dst [NW];
    bit [17:0] m_lo  [NW];
    bit [17:0] m_hi  [NW];
    bit        m_byp;

    // expected result pending for the next cycle
    bit [11:0] exp_q [$];
    string     tag_q [$];

    function automatic bit [31:0] mread(bit [8:0] a);
        int w;
        w = int'(a[7:4]);
        if (a[8]) return (a[7:0] == 0) ? {30'd0, m_byp, 1'b0} : 32'd0;
        case (a[3:2])
            2'd0: return {20'd0, m_dst[w], 7'd0, m_en[w]};
            2'd2: return {4'd0, m_lo[w], 10'd0};
            2'd3: return {4'd0, m_hi[w], 10'd0};
            default: return 32'd0;
        endcase
    endfunction

    // packed: valid, hit, miss, 1'b0, target[3:0], index[3:0]
    function automatic bit [11:0] mlook(bit v, bit [43:0] a);
        bit [17:0] s;
        s = a[43:26];
        if (!v) return 12'd0;
        for (int w = 0; w < NW; w++)
            if (m_en[w] && s >= m_lo[w] && s <= m_hi[w])
                return {1'b1, 1'b1, 1'b0, 1'b0, m_dst[w], 4'(w)};
        return m_byp ? {1'b1, 11'd0} : {1'b1, 1'b0, 1'b1, 9'd0};
    endfunction

    function automatic bit [11:0] got();
        return {res_valid, res_hit, res_miss, 1'b0, res_target, res_index};
    endfunction

    task automatic step(bit wr, bit [8:0] a, bit [31:0] d, bit v, bit [43:0] la, string tag);
        bit [11:0] e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (got() !== e) begin
            failures++;
            $display("FAIL %s result got=%h exp=%h", t, got(), e);
        end
        reg_wr = wr; reg_addr = a; reg_wdata = d; lk_valid = v; lk_addr = la;
        exp_q.push_back(mlook(v, la));
        tag_q.push_back(tag);
        #1;
        checks++;
        if (reg_rdata !== mread(a)) begin
            failures++;
            $display("FAIL %s readback @%h got=%h exp=%h", tag, a, reg_rdata, mread(a));
        end
        @(posedge clk);
        if (wr) begin
            if (a[8]) begin
                if (a[7:0] == 0) m_byp = d[1];
            end else begin
                case (a[3:2])
                    2'd0: begin m_en[a[7:4]] = d[0]; m_dst[a[7:4]] = d[11:8]; end
                    2'd2: m_lo[a[7:4]] = d[27:10];
                    2'd3: m_hi[a[7:4]] = d[27:10];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(bit [8:0] a, bit [31:0] d, string tag);
        step(1'b1, a, d, 1'b0, 44'd0, tag);
    endtask
    task automatic rd(bit [8:0] a, string tag);
        step(1'b0, a, 32'd0, 1'b0, 44'd0, tag);
    endtask
    task automatic look(bit [17:0] s, bit [25:0] lowb, string tag);
        step(1'b0, 9'd0, 32'd0, 1'b1, {s, lowb}, tag);
    endtask
    task automatic idle(string tag);
        step(1'b0, 9'd0, 32'd0, 1'b0, 44'd0, tag);
    endtask
    task automatic setwin(int w, bit en, bit [3:0] dst, bit [17:0] lo, bit [17:0] hi, string tag);
        wr(9'(w * 16 + 8),  {4'd0, lo, 10'd0}, tag);
        wr(9'(w * 16 + 12), {4'd0, hi, 10'd0}, tag);
        wr(9'(w * 16),      {20'd0, dst, 7'd0, en}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_byp = 0;
        for (int w = 0; w < NW; w++) begin
            m_en[w] = 0; m_dst[w] = 0; m_lo[w] = 0; m_hi[w] = 0;
        end
        exp_q.push_back(12'd0);
        tag_q.push_back("R1 reset outputs");
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int a = 0; a < 16 * NW; a += 4) rd(9'(a), "R1 reset readback");
        rd(9'h100, "R1 reset bypass");
        idle("R1 idle outputs");

        // R2 / R3: field masking and layout
        wr(9'h030, 32'hFFFF_FFFF, "R2 ctrl write");
        rd(9'h030, "R2 ctrl readback 0xF01");
        wr(9'h038, 32'hFFFF_FFFF, "R3 low write");
        rd(9'h038, "R3 low readback");
        wr(9'h03C, 32'hA5A5_5A5A, "R3 high write");
        rd(9'h03C, "R3 high readback");
        wr(9'h034, 32'hFFFF_FFFF, "R3 gap offset");
        rd(9'h034, "R3 gap offset reads zero");
        wr(9'h030, 32'h0000_0000, "R2 disable");
        rd(9'h030, "R2 ctrl cleared");

        // programme windows
        setwin(0,  1, 4'h5, 18'h10,  18'h1F,  "R4 setup");
        setwin(1,  1, 4'h9, 18'h18,  18'h30,  "R6 setup");
        setwin(2,  0, 4'h7, 18'h40,  18'h50,  "R5 setup");
        setwin(15, 1, 4'hC, 18'h100, 18'h100, "R4 setup");
        rd(9'h0F0, "R2 window 15 ctrl");
        rd(9'h028, "R3 window 2 low");

        // R4: inclusive bounds, low bits ignored
        look(18'h10, 26'd0, "R4 low bound");
        look(18'h1F, 26'h3FF_FFFF, "R4 high bound low bits set");
        look(18'h0F, 26'h3FF_FFFF, "R4 below low bound");
        look(18'h100, 26'h155_5555, "R4 single slice window");
        idle("R9 gap");
        // R6: overlap, lowest number wins
        look(18'h18, 26'd0, "R6 overlap");
        look(18'h1F, 26'd1, "R6 overlap top");
        look(18'h20, 26'd0, "R6 second window only");
        look(18'h30, 26'd0, "R4 high bound window 1");
        // R7: miss pulses
        look(18'h31, 26'd0, "R7 miss");
        idle("R7 miss is one cycle");
        look(18'h3FFFF, 26'd0, "R7 miss top");
        look(18'h31, 26'd0, "R7 back to back miss");
        // R5: disabled window
        look(18'h45, 26'd0, "R5 disabled window");
        idle("R9 idle");
        idle("R9 idle");

        // R11 / R8: bypass
        wr(9'h100, 32'hFFFF_FFFF, "R11 bypass write");
        rd(9'h100, "R11 bypass readback 0x2");
        rd(9'h104, "R11 neighbour reads zero");
        look(18'h31, 26'd0, "R8 bypass unmatched");
        look(18'h45, 26'd0, "R8 bypass disabled window");
        look(18'h10, 26'd0, "R8 bypass hit unaffected");

        // R10: write coincides with lookup
        step(1'b1, 9'h020, 32'h0000_0701, 1'b1, {18'h45, 26'd0}, "R10 same cycle old config");
        look(18'h45, 26'd0, "R10 next lookup new config");
        step(1'b1, 9'h000, 32'h0000_0000, 1'b1, {18'h12, 26'd0}, "R10 disable same cycle");
        look(18'h12, 26'd0, "R10 after disable");
        step(1'b1, 9'h100, 32'h0000_0000, 1'b1, {18'h31, 26'd0}, "R10 bypass clear same cycle");
        look(18'h31, 26'd0, "R7 miss after bypass clear");
        look(18'h50, 26'h3FF_FFFF, "R4 window 2 high bound");
        idle("R9 final");
        idle("R9 final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule